// File: doc/BRIEF.md
# NAND Flash Asynchronous Strobe Sequencer

This block turns single-cycle host requests into the pin-level waveform of an 8-bit asynchronous NAND flash bus. The host presents a byte address, a direction, write data and a valid strobe while the block is idle. The block captures the request and the 32-bit timing word, then walks through four phases: setup, strobe, hold and turnaround. Chip enable, write enable and read enable are derived from the current phase. Each phase has its own programmable length, with separate lengths for reads and writes.

The command-latch and address-latch lines are taken from two fixed bits of the captured byte address. The flash data bus is driven for the whole active window of a write. For a read, the bus is sampled once, on the final strobe cycle. A select-strobe mode narrows chip enable to the strobe phase only. A separate flag mirrors the wire-ANDed ready/busy line of the flash devices.

Top module: `nand_strobe_gen`

## Requirements
- R1: With busy low, a request with req_valid high is accepted on the rising edge. busy is high from the following cycle until the last turnaround cycle ends. A request presented while busy is high is ignored, and the captured address, direction, data and timing word stay unchanged.
- R2: The setup phase lasts setup+1 cycles. Setup comes from timing bits 29:26 for writes and bits 16:13 for reads. During setup nand_ce_n is low and both nand_we_n and nand_re_n are high.
- R3: The strobe phase lasts strobe+1 cycles. Strobe comes from bits 25:20 for writes and bits 12:7 for reads. nand_we_n is low throughout a write strobe, nand_re_n is low throughout a read strobe, and the two are never low together.
- R4: The hold phase lasts hold+1 cycles. Hold comes from bits 19:17 for writes and bits 6:4 for reads. During hold nand_ce_n is low and both strobes are high.
- R5: The turnaround phase lasts turnaround+1 cycles, with turnaround taken from bits 3:2. During turnaround nand_ce_n is high, the strobes are high, the data bus is released and busy stays high.
- R6: nand_cle is high during setup, strobe and hold when byte-address bit 4 is set. nand_ale is high in the same window when bit 3 is set and bit 4 is clear. Both lines are low at all other times, and no other address bit, including bits 1:0, affects any output.
- R7: For a write, nand_dq_oe is high and nand_dq_out carries the captured data from the first setup cycle to the last hold cycle. At all other times nand_dq_oe is low and nand_dq_out is zero.
- R8: For a read, nand_dq_in is sampled on the last strobe cycle. rd_data holds that byte and rd_valid is high for exactly one cycle, the first hold cycle. Writes never raise rd_valid.
- R9: When timing bit 31 (select-strobe) is set, nand_ce_n is low only during the strobe phase. The phase lengths, data and latch lines are unchanged.
- R10: flash_ready equals nand_rdy (1 = ready) delayed by one clock.
- R11: While reset is applied and after its release with no request, busy, rd_valid, nand_ale, nand_cle, nand_dq_oe and flash_ready are low, and nand_ce_n, nand_we_n and nand_re_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_timing | input | 32 | Packed timing word, captured at acceptance |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 3 and 4 select ALE and CLE |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | High from acceptance until the end of turnaround |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| rd_data | output | DATA_W | Captured read byte |
| flash_ready | output | 1 | Registered copy of nand_rdy |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_we_n | output | 1 | Flash write enable, active low |
| nand_re_n | output | 1 | Flash read enable, active low |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_dq_out | output | DATA_W | Data driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | DATA_W | Data returned by the flash |
| nand_rdy | input | 1 | Wire-ANDed ready/busy line |

## Verification
Call the accepting rising edge cycle 0 and let S, T, H and R be the four phase lengths (field+1). The pins then follow the phases with no added delay: setup covers cycles 0 to S-1, strobe covers S to S+T-1, hold and turnaround follow, and busy first reads low in cycle S+T+H+R. rd_valid and rd_data appear in cycle S+T, one register after the sampling cycle, and flash_ready lags nand_rdy by one cycle. The bench drives inputs on falling edges and compares every output at each falling edge against a phase computed from the cycle count. On the last strobe cycle only it presents the real read byte, so a sample taken in any other cycle is exposed. While busy is high it scrambles the request inputs and the timing word, to show that none of them are taken.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  localparam int TIMING_W = 32;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } nsg_phase_e;

  // Field order follows the bit positions of the timing word, MSB first.
  typedef struct packed {
    logic       sel_strobe;  // 31
    logic       ext_wait;    // 30, must stay clear for flash
    logic [3:0] wr_setup;    // 29:26
    logic [5:0] wr_strobe;   // 25:20
    logic [2:0] wr_hold;     // 19:17
    logic [3:0] rd_setup;    // 16:13
    logic [5:0] rd_strobe;   // 12:7
    logic [2:0] rd_hold;     // 6:4
    logic [1:0] turn;        // 3:2
    logic [1:0] bus_size;    // 1:0, zero = 8-bit
  } nsg_timing_t;

  function automatic nsg_timing_t nsg_unpack(input logic [TIMING_W-1:0] word);
    return nsg_timing_t'(word);
  endfunction

endpackage

// File: rtl/nsg_phase_len.sv
module nsg_phase_len
  import nsg_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  nsg_timing_t      tim,
  input  logic             is_wr,
  input  nsg_phase_e       ph,
  output logic [CNT_W-1:0] len
);

  always_comb begin
    len = '0;
    case (ph)
      PH_SETUP:  len = is_wr ? CNT_W'(tim.wr_setup)  : CNT_W'(tim.rd_setup);
      PH_STROBE: len = is_wr ? CNT_W'(tim.wr_strobe) : CNT_W'(tim.rd_strobe);
      PH_HOLD:   len = is_wr ? CNT_W'(tim.wr_hold)   : CNT_W'(tim.rd_hold);
      PH_TURN:   len = CNT_W'(tim.turn);
      default:   len = '0;
    endcase
  end

endmodule

// File: rtl/nsg_phase_seq.sv
module nsg_phase_seq
  import nsg_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len_nx,
  output nsg_phase_e       phase,
  output nsg_phase_e       phase_nx,
  output logic             last
);

  nsg_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign phase = ph_q;
  assign last  = (cnt_q == '0);

  always_comb begin
    phase_nx = ph_q;
    case (ph_q)
      PH_IDLE:   if (start) phase_nx = PH_SETUP;
      PH_SETUP:  if (last)  phase_nx = PH_STROBE;
      PH_STROBE: if (last)  phase_nx = PH_HOLD;
      PH_HOLD:   if (last)  phase_nx = PH_TURN;
      PH_TURN:   if (last)  phase_nx = PH_IDLE;
      default:              phase_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (phase_nx != ph_q) begin
      cnt_en = 1'b1;
      cnt_d  = len_nx;
    end else if (!last) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= phase_nx;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (cnt_q == '0)); // R1

endmodule

// File: rtl/nsg_pin_drive.sv
module nsg_pin_drive
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  nsg_phase_e        phase,
  input  logic              sel_strobe,
  input  logic              is_wr,
  input  logic              bit_ale,
  input  logic              bit_cle,
  input  logic [DATA_W-1:0] wdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic              ale,
  output logic              cle,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic act;
  logic stb;

  always_comb begin
    act    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    stb    = (phase == PH_STROBE);
    ce_n   = sel_strobe ? !stb : !act;
    we_n   = !(stb && is_wr);
    re_n   = !(stb && !is_wr);
    cle    = act && bit_cle;
    ale    = act && bit_ale && !bit_cle;
    dq_oe  = act && is_wr;
    dq_out = dq_oe ? wdata : '0;
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ALE_BIT     = 3,
  parameter int CLE_BIT     = 4,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_timing,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              flash_ready,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rdy
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_MSB:0] rs_q;
  logic              rst_sync_n;

  generate
    if (SYNC_STAGES > 1) begin : g_rsync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_MSB-1:0], 1'b1};
      end
    end else begin : g_rsync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_sync_n = rs_q[SYNC_MSB];

  // Sequencer and length selection
  nsg_phase_e       phase;
  nsg_phase_e       phase_nx;
  logic             last;
  logic [CNT_W-1:0] len_nx;
  logic             accept;

  nsg_timing_t       tim_q;
  nsg_timing_t       tim_src;
  logic              wr_q;
  logic              wr_src;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept  = req_valid && (phase == PH_IDLE);
  assign tim_src = accept ? nsg_unpack(cfg_timing) : tim_q;
  assign wr_src  = accept ? req_write : wr_q;
  assign busy    = (phase != PH_IDLE);

  nsg_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .len_nx   (len_nx),
    .phase    (phase),
    .phase_nx (phase_nx),
    .last     (last)
  );

  nsg_phase_len #(.CNT_W(CNT_W)) u_len (
    .tim   (tim_src),
    .is_wr (wr_src),
    .ph    (phase_nx),
    .len   (len_nx)
  );

  // Request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tim_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      tim_q   <= nsg_unpack(cfg_timing);
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Read capture on the final strobe cycle
  logic rd_cap;
  logic rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign rd_cap = (phase == PH_STROBE) && last && !wr_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_cap;
      if (rd_cap) rd_data_q <= nand_dq_in;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // Ready mirror
  logic rdy_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdy_q <= 1'b0;
    else             rdy_q <= nand_rdy;
  end
  assign flash_ready = rdy_q;

  nsg_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .phase      (phase),
    .sel_strobe (tim_q.sel_strobe),
    .is_wr      (wr_q),
    .bit_ale    (addr_q[ALE_BIT]),
    .bit_cle    (addr_q[CLE_BIT]),
    .wdata      (wdata_q),
    .ce_n       (nand_ce_n),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .ale        (nand_ale),
    .cle        (nand_cle),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe)
  );

  // Assertions
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!nand_we_n && !nand_re_n)); // R3

  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R9

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(nand_ale && nand_cle)); // R6

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_valid |=> !rd_valid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q) && $stable(tim_q))); // R1

  AST_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_TURN) |-> (nand_ce_n && !nand_dq_oe && busy)); // R5

  AST_FLASH_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |-> (!cfg_timing[30] && (cfg_timing[1:0] == 2'b00))); // R2

endmodule

// File: tb/sim_nand_strobe_gen.sv
module sim_nand_strobe_gen;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_timing;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        flash_ready;
  logic        nand_ce_n;
  logic        nand_we_n;
  logic        nand_re_n;
  logic        nand_ale;
  logic        nand_cle;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in;
  logic        nand_rdy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nand_strobe_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_timing  (cfg_timing),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .flash_ready (flash_ready),
    .nand_ce_n   (nand_ce_n),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_ale    (nand_ale),
    .nand_cle    (nand_cle),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_in  (nand_dq_in),
    .nand_rdy    (nand_rdy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit sel, input int ws, input int wt,
      input int wh, input int rs, input int rt, input int rh, input int ta);
    logic [31:0] w;
    w = {sel, 1'b0, 4'(ws), 6'(wt), 3'(wh), 4'(rs), 6'(rt), 3'(rh), 2'(ta), 2'b00};
    return w;
  endfunction

  // Per-access mismatch bookkeeping, indexed by requirement number
  bit bad [12];
  int fa  [12];
  int fe  [12];

  function automatic void note(input int idx, input int act, input int exp);
    if (act != exp && !bad[idx]) begin
      bad[idx] = 1'b1;
      fa[idx]  = act;
      fe[idx]  = exp;
    end
  endfunction

  // Caller is at a falling edge with busy low.
  task automatic do_acc(input logic [31:0] cfg, input bit wr, input logic [15:0] addr,
                        input logic [7:0] wd, input logic [7:0] rv);
    int s, t, h, r, len;
    bit sel;
    sel = cfg[31];
    s = wr ? int'(cfg[29:26]) : int'(cfg[16:13]);
    t = wr ? int'(cfg[25:20]) : int'(cfg[12:7]);
    h = wr ? int'(cfg[19:17]) : int'(cfg[6:4]);
    s = s + 1; t = t + 1; h = h + 1;
    r = int'(cfg[3:2]) + 1;
    len = s + t + h + r;
    for (int i = 0; i < 12; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end

    cfg_timing = cfg;
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = addr;
    req_wdata  = wd;
    nand_dq_in = ~rv;
    @(posedge clk);
    for (int k = 0; k <= len; k++) begin
      bit act, stb, e_ce, e_we, e_re, e_cle, e_ale, e_oe, e_busy, e_rdv;
      int pidx;
      logic [7:0] e_dq;
      @(negedge clk);
      // scramble inputs: a busy block must ignore them (R1)
      cfg_timing = ~cfg & 32'hBFFF_FFFC;
      req_write  = ~wr;
      req_addr   = ~addr;
      req_wdata  = ~wd;

      act    = (k < s + t + h);
      stb    = (k >= s) && (k < s + t);
      e_ce   = sel ? !stb : !act;
      e_we   = !(stb && wr);
      e_re   = !(stb && !wr);
      e_cle  = act && addr[4];
      e_ale  = act && addr[3] && !addr[4];
      e_oe   = act && wr;
      e_dq   = e_oe ? wd : 8'h00;
      e_busy = (k < len);
      e_rdv  = !wr && (k == s + t);

      if (sel)                 pidx = 9;
      else if (k < s)          pidx = 2;
      else if (k < s + t)      pidx = 3;
      else if (k < s + t + h)  pidx = 4;
      else if (k < len)        pidx = 5;
      else                     pidx = 1;

      note(pidx, {nand_ce_n, nand_we_n, nand_re_n}, {e_ce, e_we, e_re});
      note(1, busy, e_busy);
      note(6, {nand_cle, nand_ale}, {e_cle, e_ale});
      note(7, {nand_dq_oe, nand_dq_out}, {e_oe, e_dq});
      note(8, rd_valid, e_rdv);
      if (!wr && k == s + t) note(8, rd_data, rv);

      nand_dq_in = (k == s + t - 1) ? rv : ~rv;
      if (k == len - 1) req_valid = 1'b0;
    end

    chk(!bad[1], "R1", "busy window / ignored request", fa[1], fe[1]);
    if (sel) begin
      chk(!bad[9], "R9", "select-strobe ce/we/re", fa[9], fe[9]);
    end else begin
      chk(!bad[2], "R2", "setup ce/we/re", fa[2], fe[2]);
      chk(!bad[3], "R3", "strobe ce/we/re", fa[3], fe[3]);
      chk(!bad[4], "R4", "hold ce/we/re", fa[4], fe[4]);
      chk(!bad[5], "R5", "turnaround ce/we/re", fa[5], fe[5]);
    end
    chk(!bad[6], "R6", "cle/ale", fa[6], fe[6]);
    chk(!bad[7], "R7", "dq_oe/dq_out", fa[7], fe[7]);
    chk(!bad[8], "R8", "read capture", fa[8], fe[8]);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sv [3];
    int tv [3];
    int hv [3];
    logic [15:0] av [5];
    int n;
    sv = '{0, 2, 15};
    tv = '{0, 5, 63};
    hv = '{0, 3, 7};
    av = '{16'h0000, 16'h0008, 16'h0010, 16'h001B, 16'hFFE7};
    n = 0;

    rst_n      = 1'b0;
    cfg_timing = '0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_addr   = '0;
    req_wdata  = '0;
    nand_dq_in = '0;
    nand_rdy   = 1'b1;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk({busy, rd_valid, nand_ale, nand_cle, nand_dq_oe, flash_ready,
         nand_ce_n, nand_we_n, nand_re_n} == 9'b000000111, "R11", "outputs in reset",
        {busy, rd_valid, nand_ale, nand_cle, nand_dq_oe, flash_ready,
         nand_ce_n, nand_we_n, nand_re_n}, 9'b000000111);
    rst_n = 1'b1;
    nand_rdy = 1'b0;
    repeat (5) @(negedge clk);
    chk({busy, rd_valid, nand_ale, nand_cle, nand_dq_oe, flash_ready,
         nand_ce_n, nand_we_n, nand_re_n} == 9'b000000111, "R11", "outputs after reset",
        {busy, rd_valid, nand_ale, nand_cle, nand_dq_oe, flash_ready,
         nand_ce_n, nand_we_n, nand_re_n}, 9'b000000111);

    // R10: ready mirror, one cycle of delay
    for (int i = 0; i < 6; i++) begin
      logic v;
      v = (i % 3) != 1;
      nand_rdy = v;
      @(negedge clk);
      chk(flash_ready == v, "R10", "flash_ready", flash_ready, v);
    end

    // Sweep of phase lengths, both directions, rotating address patterns
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int r = 0; r < 4; r++) begin
            logic [31:0] cw, cr;
            cw = mk_cfg(1'b0, sv[a], tv[b], hv[c], 15 - sv[a], 63 - tv[b], 7 - hv[c], r);
            cr = mk_cfg(1'b0, 15 - sv[a], 63 - tv[b], 7 - hv[c], sv[a], tv[b], hv[c], r);
            do_acc(cw, 1'b1, av[n % 5], 8'(8'hA5 + n), 8'h00);
            n++;
            do_acc(cr, 1'b0, av[n % 5], 8'h00, 8'(8'h3C ^ n));
            n++;
          end

    // R9: select-strobe mode
    do_acc(mk_cfg(1'b1, 2, 3, 1, 0, 0, 0, 1), 1'b1, 16'h0010, 8'h5A, 8'h00);
    do_acc(mk_cfg(1'b1, 0, 0, 0, 3, 4, 2, 0), 1'b0, 16'h0008, 8'h00, 8'hC3);
    do_acc(mk_cfg(1'b1, 0, 0, 0, 0, 0, 0, 3), 1'b0, 16'h0003, 8'h00, 8'h81);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule